// File: doc/BRIEF.md
# Multi-Buffer SPI Master Sequencer

This block is an SPI master that works through a small on-chip buffer memory. Each transmit entry pairs a 16-bit control word with a 16-bit data word. Software fills the entries through a simple write port and picks a run of consecutive entries as a transfer group, given by a start index and a length. A trigger then starts the group. The sequencer shifts each entry out in index order and stores each received word in the receive entry with the same index. At the end it raises a one-cycle group-done pulse.

Chip-select is decided one word at a time. A hold bit in each control word keeps the selected lines asserted after that word. Because of this, one logical transaction can run longer than a group: software triggers the group again and the lines stay low between the passes. A held chip-select is released in one of three ways:

- a later word whose hold bit is clear;
- a later word that selects different lines;
- an explicit release command while idle.

None of these touches the group settings or the buffer contents, so the next trigger starts normally.

Top module: `mbSpiSeq`

## Requirements
- R1: After reset, all four active-low chip-select lines are high, SCLK is low, and busy, group-done and the error flag are all low.
- R2: An accepted trigger sends the entries from the start index to start+length-1 in index order, wrapping modulo the buffer depth. Each data word goes out MSB first on MOSI, which is stable at every SCLK rising edge.
- R3: For each word, MISO is sampled on the 16 SCLK rising edges. The 16-bit word is stored MSB first in the receive entry with the same index, and software can read it back on the read port.
- R4: SCLK idles low. Each half period is clkDiv+1 system clocks, and one word takes 16 full SCLK periods.
- R5: While a word shifts, csN equals the bitwise inverse of bits 3:0 of its control word.
- R6: When a word's hold flag (control bit 12) is clear, all chip-select lines go high after that word. This lasts at least one clock before the next word, and stays so after the last word of a group.
- R7: When a word's hold flag is set, csN keeps its value after that word. This holds into the next word of the group, through the idle time after the group, and into the next pass, without a high gap.
- R8: Group-done is a single-cycle pulse, raised once per pass after the last received word is stored. Busy is low from that cycle on.
- R9: A trigger that arrives while busy is ignored: the running pass completes unchanged. Such a trigger sets the error flag. A trigger with length 0 is also rejected and sets the flag. The next accepted trigger clears the flag.
- R10: A release command while idle drives all chip-select lines high in the next cycle. The buffers and the following trigger are unaffected. A release command while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for a transmit entry |
| wrAddr | input | AW | Transmit entry index to write |
| wrCtrl | input | 16 | Control word: bits 3:0 line select, bit 12 hold |
| wrData | input | 16 | Data word to transmit |
| rdAddr | input | AW | Receive entry index to read |
| rdData | output | 16 | Receive entry contents (combinational read) |
| grpStart | input | AW | First entry of the group |
| grpLen | input | AW+1 | Number of entries in the group, 1..NBUF |
| clkDiv | input | DIVW | SCLK half period minus one, in system clocks |
| trigger | input | 1 | Start the group |
| csRelease | input | 1 | Release a held chip-select while idle |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 4 | Active-low chip-select lines |
| busy | output | 1 | A group pass is running |
| grpDone | output | 1 | One-cycle pulse at the end of a pass |
| errFlag | output | 1 | A trigger was rejected |

## Verification
The bench uses the default eight-entry buffer and a 4-bit divider. It ties MISO to the inverse of MOSI, so every received word is simply the complement of the word sent. This lets the bench sweep every group length from 1 to 8 against divider settings 0 to 3, with start indices chosen so that many groups wrap past the last entry. The small depth also makes it cheap to chain two passes with held chip-select, to mix held and released words inside one group, and to fire triggers and release commands in the middle of a pass.

// File: rtl/mbSpiPkg.sv
`timescale 1ns/1ps
package mbSpiPkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned CS_W     = 4;
  localparam int unsigned HOLD_BIT = 12;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // fetch entry, select lines, restart shift
    logic run;    // shift engine active
    logic csOff;  // drive every select line high
  } seqStrb_t;
endpackage

// File: rtl/mbSpiCtrl.sv
`timescale 1ns/1ps
module mbSpiCtrl
  import mbSpiPkg::*;
#(
  parameter int unsigned NBUF = 8,
  localparam int unsigned AW = $clog2(NBUF)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          trigger,
  input  logic          csRelease,
  input  logic [AW-1:0] grpStart,
  input  logic [AW:0]   grpLen,
  input  logic          wordDone,
  input  logic          holdCur,
  output seqStrb_t      strb,
  output logic [AW-1:0] idx,
  output logic          busy,
  output logic          grpDone,
  output logic          errFlag
);
  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SHIFT} seqState_t;

  localparam logic [AW:0] LEN_MAX = (AW+1)'(NBUF);

  seqState_t     state;
  logic [AW-1:0] lastIdx;
  logic          lenOk;

  assign lenOk = (grpLen != '0) && (grpLen <= LEN_MAX);
  assign busy  = (state != S_IDLE);

  always_comb begin
    strb.load  = (state == S_LOAD);
    strb.run   = (state == S_SHIFT);
    strb.csOff = (state == S_IDLE && csRelease && !trigger) ||
                 (state == S_SHIFT && wordDone && !holdCur);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      idx     <= '0;
      lastIdx <= '0;
      grpDone <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      grpDone <= 1'b0;
      case (state)
        S_IDLE: begin
          if (trigger) begin
            if (lenOk) begin
              idx     <= grpStart;
              lastIdx <= grpStart + grpLen[AW-1:0] - AW'(1);
              errFlag <= 1'b0;
              state   <= S_LOAD;
            end else begin
              errFlag <= 1'b1;
            end
          end
        end
        S_LOAD: begin
          if (trigger) errFlag <= 1'b1;
          state <= S_SHIFT;
        end
        default: begin
          if (trigger) errFlag <= 1'b1;
          if (wordDone) begin
            if (idx == lastIdx) begin
              state   <= S_IDLE;
              grpDone <= 1'b1;
            end else begin
              idx   <= idx + AW'(1);
              state <= S_LOAD;
            end
          end
        end
      endcase
    end
  end

  // R9: a trigger seen while busy leaves the error flag set
  a_r9_busy_trigger_err: assert property (@(posedge clk) disable iff (!rstN)
    busy && trigger |=> errFlag);
  // R8: the pulse coincides with the sequencer being idle
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    grpDone |-> !busy);
  // R8: pulse lasts a single cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    grpDone |=> !grpDone);
endmodule

// File: rtl/mbSpiDp.sv
`timescale 1ns/1ps
module mbSpiDp
  import mbSpiPkg::*;
#(
  parameter int unsigned NBUF = 8,
  parameter int unsigned DIVW = 4,
  localparam int unsigned AW  = $clog2(NBUF),
  localparam int unsigned BCW = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [WORD_W-1:0] wrCtrl,
  input  logic [WORD_W-1:0] wrData,
  input  logic [AW-1:0]     rdAddr,
  output logic [WORD_W-1:0] rdData,
  input  seqStrb_t          strb,
  input  logic [AW-1:0]     idx,
  input  logic [DIVW-1:0]   clkDiv,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [CS_W-1:0]   csN,
  output logic              wordDone,
  output logic              holdCur
);
  logic [WORD_W-1:0] txData [NBUF];
  logic [CS_W-1:0]   txSel  [NBUF];
  logic              txHold [NBUF];
  logic [WORD_W-1:0] rxMem  [NBUF];

  logic [WORD_W-1:0] sh;
  logic              rxBit;
  logic [BCW-1:0]    bitCnt;
  logic [DIVW-1:0]   divCnt;
  logic              sclkQ;
  logic [CS_W-1:0]   csQ;
  logic              holdQ;
  logic              tick;
  logic              unusedCtrlBits;

  assign unusedCtrlBits = ^{wrCtrl[WORD_W-1:HOLD_BIT+1], wrCtrl[HOLD_BIT-1:CS_W]};

  assign tick     = strb.run && (divCnt == clkDiv);
  assign wordDone = tick && sclkQ && (bitCnt == BCW'(WORD_W-1));
  assign rdData   = rxMem[rdAddr];
  assign sclk     = sclkQ;
  assign mosi     = sh[WORD_W-1];
  assign csN      = csQ;
  assign holdCur  = holdQ;

  always_ff @(posedge clk) begin
    if (wrEn) begin
      txData[wrAddr] <= wrData;
      txSel[wrAddr]  <= wrCtrl[CS_W-1:0];
      txHold[wrAddr] <= wrCtrl[HOLD_BIT];
    end
    if (wordDone) rxMem[idx] <= {sh[WORD_W-2:0], rxBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sh     <= '0;
      rxBit  <= 1'b0;
      bitCnt <= '0;
      divCnt <= '0;
      sclkQ  <= 1'b0;
      csQ    <= '1;
      holdQ  <= 1'b0;
    end else begin
      if (strb.load) begin
        sh     <= txData[idx];
        holdQ  <= txHold[idx];
        csQ    <= ~txSel[idx];
        divCnt <= '0;
        sclkQ  <= 1'b0;
        bitCnt <= '0;
      end else if (strb.run) begin
        if (tick) begin
          divCnt <= '0;
          sclkQ  <= ~sclkQ;
          if (!sclkQ) begin
            rxBit <= miso;
          end else begin
            sh     <= {sh[WORD_W-2:0], rxBit};
            bitCnt <= bitCnt + BCW'(1);
          end
        end else begin
          divCnt <= divCnt + DIVW'(1);
        end
      end
      if (strb.csOff) csQ <= '1;
    end
  end

  // R4: serial clock rests low outside shifting
  a_r4_sclk_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |-> !sclkQ);
  // R5: select lines do not move while a word shifts
  a_r5_cs_steady: assert property (@(posedge clk) disable iff (!rstN)
    strb.run && $past(strb.run) |-> $stable(csQ));
  // R6: an unheld word releases every line
  a_r6_release_after_word: assert property (@(posedge clk) disable iff (!rstN)
    wordDone && !holdQ |=> (&csQ));
  // R7: a held word keeps the lines as they were
  a_r7_hold_keeps: assert property (@(posedge clk) disable iff (!rstN)
    wordDone && holdQ |=> $stable(csQ));
endmodule

// File: rtl/mbSpiSeq.sv
`timescale 1ns/1ps
module mbSpiSeq
  import mbSpiPkg::*;
#(
  parameter int unsigned NBUF = 8,
  parameter int unsigned DIVW = 4,
  localparam int unsigned AW  = $clog2(NBUF)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [WORD_W-1:0] wrCtrl,
  input  logic [WORD_W-1:0] wrData,
  input  logic [AW-1:0]     rdAddr,
  output logic [WORD_W-1:0] rdData,
  input  logic [AW-1:0]     grpStart,
  input  logic [AW:0]       grpLen,
  input  logic [DIVW-1:0]   clkDiv,
  input  logic              trigger,
  input  logic              csRelease,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [CS_W-1:0]   csN,
  output logic              busy,
  output logic              grpDone,
  output logic              errFlag
);
  seqStrb_t      strb;
  logic [AW-1:0] idx;
  logic          wordDone;
  logic          holdCur;

  mbSpiCtrl #(.NBUF(NBUF)) ctrl_i (
    .clk(clk), .rstN(rstN), .trigger(trigger), .csRelease(csRelease),
    .grpStart(grpStart), .grpLen(grpLen), .wordDone(wordDone),
    .holdCur(holdCur), .strb(strb), .idx(idx), .busy(busy),
    .grpDone(grpDone), .errFlag(errFlag)
  );

  mbSpiDp #(.NBUF(NBUF), .DIVW(DIVW)) dp_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrCtrl(wrCtrl),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .strb(strb),
    .idx(idx), .clkDiv(clkDiv), .miso(miso), .sclk(sclk), .mosi(mosi),
    .csN(csN), .wordDone(wordDone), .holdCur(holdCur)
  );

  // R10: release command while idle frees every line next cycle
  a_r10_release_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy && csRelease && !trigger |=> (&csN));
endmodule

// File: tb/mbSpiSeq_tb_top.sv
`timescale 1ns/1ps
module mbSpiSeq_tb_top;
  localparam int NBUF = 8;
  localparam int AW   = 3;
  localparam int DIVW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0, wrEn = 1'b0, trigger = 1'b0, csRelease = 1'b0;
  logic [AW-1:0] wrAddr = '0, rdAddr = '0, grpStart = '0;
  logic [AW:0] grpLen = '0;
  logic [DIVW-1:0] clkDiv = '0;
  logic [15:0] wrCtrl = '0, wrData = '0, rdData;
  logic sclk, mosi, miso, busy, grpDone, errFlag;
  logic [3:0] csN;

  assign miso = ~mosi;

  mbSpiSeq #(.NBUF(NBUF), .DIVW(DIVW)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrCtrl(wrCtrl),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .grpStart(grpStart),
    .grpLen(grpLen), .clkDiv(clkDiv), .trigger(trigger), .csRelease(csRelease),
    .sclk(sclk), .mosi(mosi), .miso(miso), .csN(csN), .busy(busy),
    .grpDone(grpDone), .errFlag(errFlag)
  );

  int checks = 0, errors = 0;

  // serial monitor
  logic [15:0] capW [0:1023];
  logic [3:0]  capC [0:1023];
  int capN = 0, capBits = 0, sclkBad = 0, gapCnt = 0, doneCnt = 0;
  logic [15:0] capSh = '0;
  time lastRise = 0, expPer = 20;

  always @(posedge sclk) begin
    if (capBits != 0 && ($time - lastRise) != expPer) sclkBad++;
    lastRise = $time;
    capSh = {capSh[14:0], mosi};
    capBits++;
    if (capBits == 16) begin
      capW[capN] = capSh;
      capC[capN] = csN;
      capN++;
      capBits = 0;
    end
  end

  always @(negedge clk) begin
    if (busy === 1'b1 && csN === 4'hF) gapCnt++;
    if (grpDone === 1'b1) doneCnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  function automatic logic [15:0] dval(input int k, input int p);
    return 16'h9A3C ^ 16'(k * 16'h1357) ^ 16'(p * 16'h0F21);
  endfunction

  task automatic writeEntry(input int k, input logic [15:0] c, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = AW'(k); wrCtrl = c; wrData = d;
    step();
    wrEn = 1'b0;
  endtask

  task automatic pulseTrigger();
    trigger = 1'b1;
    step();
    trigger = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy !== 1'b0 && n < 20000) begin
      step();
      n++;
    end
    if (n >= 20000) chk(1'b0, "R8 pass timeout", 32'(busy), 0);
    step();
  endtask

  task automatic setGroup(input int s, input int l, input int dv);
    grpStart = AW'(s); grpLen = (AW+1)'(l); clkDiv = DIVW'(dv);
    expPer = time'(2 * (dv + 1) * 20);
  endtask

  task automatic checkWords(input int base, input int s, input int l, input int p,
                            input logic [15:0] ctl [8], input string tag);
    chk(capN - base == l, {tag, " R2 word count"}, 32'(capN - base), 32'(l));
    for (int j = 0; j < l; j++) begin
      int k = (s + j) % NBUF;
      chk(capW[base + j] == dval(k, p), {tag, " R2 mosi word"}, 32'(capW[base + j]), 32'(dval(k, p)));
      chk(capC[base + j] == ~ctl[j][3:0], {tag, " R5 select"}, 32'(capC[base + j]), 32'(~ctl[j][3:0]));
      rdAddr = AW'(k);
      #1;
      chk(rdData == ~dval(k, p), {tag, " R3 rx word"}, 32'(rdData), 32'(~dval(k, p)));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] ctl [8];
    int b0, g0, d0, s0, s, p;

    step(); step(); step();
    rstN = 1'b1;
    step();
    // R1 reset state
    chk(csN == 4'hF, "R1 csN", 32'(csN), 32'hF);
    chk(sclk == 1'b0 && busy == 1'b0, "R1 sclk/busy", {30'd0, sclk, busy}, 0);
    chk(grpDone == 1'b0 && errFlag == 1'b0, "R1 done/err", {30'd0, grpDone, errFlag}, 0);

    // sweep: divider x length, unheld words, wrapping starts (R2 R3 R4 R5 R6 R8)
    for (int dv = 0; dv < 4; dv++) begin
      for (int l = 1; l <= NBUF; l++) begin
        s = (l * 3 + dv) % NBUF;
        p = dv * 8 + l;
        for (int j = 0; j < l; j++) begin
          ctl[j] = 16'(1 << (j % 4));
          writeEntry((s + j) % NBUF, ctl[j], dval((s + j) % NBUF, p));
        end
        b0 = capN; g0 = gapCnt; d0 = doneCnt; s0 = sclkBad;
        setGroup(s, l, dv);
        pulseTrigger();
        waitIdle();
        checkWords(b0, s, l, p, ctl, "sweep");
        chk(sclkBad == s0, "R4 sclk half period", 32'(sclkBad - s0), 0);
        chk(gapCnt - g0 == l, "R6 release gaps", 32'(gapCnt - g0), 32'(l));
        chk(doneCnt - d0 == 1, "R8 done pulse", 32'(doneCnt - d0), 1);
        chk(csN == 4'hF && busy == 1'b0, "R6 idle released", {27'd0, busy, csN}, 32'hF);
      end
    end

    // R7: held chip-select across words and across two passes
    for (int k = 0; k < NBUF; k++) writeEntry(k, 16'h1002, dval(k, 100));
    for (int j = 0; j < 8; j++) ctl[j] = 16'h1002;
    b0 = capN; g0 = gapCnt;
    setGroup(0, 4, 0);
    pulseTrigger();
    waitIdle();
    checkWords(b0, 0, 4, 100, ctl, "hold1");
    chk(gapCnt - g0 == 1, "R7 single opening gap", 32'(gapCnt - g0), 1);
    chk(csN == 4'hD, "R7 held after pass", 32'(csN), 32'hD);
    b0 = capN; g0 = gapCnt;
    setGroup(4, 4, 0);
    pulseTrigger();
    waitIdle();
    checkWords(b0, 4, 4, 100, ctl, "hold2");
    chk(gapCnt - g0 == 0, "R7 no gap second pass", 32'(gapCnt - g0), 0);
    chk(csN == 4'hD, "R7 held after second pass", 32'(csN), 32'hD);

    // R10: release while busy is ignored
    b0 = capN; g0 = gapCnt;
    setGroup(0, 4, 1);
    pulseTrigger();
    repeat (10) step();
    csRelease = 1'b1;
    step();
    csRelease = 1'b0;
    chk(csN == 4'hD, "R10 busy release ignored", 32'(csN), 32'hD);
    waitIdle();
    checkWords(b0, 0, 4, 100, ctl, "relbusy");
    chk(gapCnt - g0 == 0, "R10 busy release no gap", 32'(gapCnt - g0), 0);

    // R10: release while idle, then a normal restart
    csRelease = 1'b1;
    step();
    csRelease = 1'b0;
    chk(csN == 4'hF, "R10 idle release", 32'(csN), 32'hF);
    chk(busy == 1'b0 && errFlag == 1'b0, "R10 state untouched", {30'd0, busy, errFlag}, 0);
    b0 = capN; g0 = gapCnt; d0 = doneCnt;
    setGroup(0, 4, 0);
    pulseTrigger();
    waitIdle();
    checkWords(b0, 0, 4, 100, ctl, "restart");
    chk(gapCnt - g0 == 1, "R10 restart opening gap", 32'(gapCnt - g0), 1);
    chk(doneCnt - d0 == 1, "R10 restart done", 32'(doneCnt - d0), 1);
    csRelease = 1'b1;
    step();
    csRelease = 1'b0;

    // R6/R7 mixed: held words then an unheld last word on another line
    for (int j = 0; j < 3; j++) begin
      ctl[j] = 16'h1004;
      writeEntry(j, ctl[j], dval(j, 200));
    end
    ctl[3] = 16'h0008;
    writeEntry(3, ctl[3], dval(3, 200));
    b0 = capN; g0 = gapCnt;
    setGroup(0, 4, 2);
    pulseTrigger();
    waitIdle();
    checkWords(b0, 0, 4, 200, ctl, "mixed");
    chk(gapCnt - g0 == 1, "R7 mixed gaps", 32'(gapCnt - g0), 1);
    chk(csN == 4'hF, "R6 mixed end released", 32'(csN), 32'hF);

    // R9: trigger while busy
    for (int j = 0; j < 8; j++) begin
      ctl[j] = 16'(1 << (j % 4));
      writeEntry(j, ctl[j], dval(j, 300));
    end
    b0 = capN; d0 = doneCnt;
    setGroup(0, 8, 1);
    pulseTrigger();
    repeat (20) step();
    grpStart = 3'd5; grpLen = 4'd2;
    pulseTrigger();
    chk(errFlag == 1'b1, "R9 busy trigger flag", 32'(errFlag), 1);
    waitIdle();
    checkWords(b0, 0, 8, 300, ctl, "busytrig");
    chk(doneCnt - d0 == 1, "R9 single done", 32'(doneCnt - d0), 1);

    // R9: zero length rejected
    grpLen = '0;
    pulseTrigger();
    step();
    chk(errFlag == 1'b1 && busy == 1'b0, "R9 zero length", {30'd0, errFlag, busy}, 32'h2);

    // R9: accepted trigger clears the flag
    b0 = capN;
    setGroup(2, 3, 0);
    pulseTrigger();
    chk(errFlag == 1'b0, "R9 flag cleared", 32'(errFlag), 0);
    waitIdle();
    checkWords(b0, 2, 3, 300, '{ctl[2], ctl[3], ctl[4], 16'h0, 16'h0, 16'h0, 16'h0, 16'h0}, "clear");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule